// File: doc/BRIEF.md
# Redundant-Stage Pipeline Converter Code Corrector

This block is the digital back end of a 14-bit pipelined analog-to-digital converter. The converter has twelve leading stages. Each leading stage has two comparators, so it resolves a three-level decision, and it passes on a residue amplified by two. The last stage is a three-comparator flash that resolves two bits. The raw comparator outputs of each stage arrive one conversion clock later than those of the stage before it. The block decodes each stage's comparator pair into a code of 0, 1 or 2. It holds each code in a skew line whose length depends on the stage's position, so that all thirteen decisions of one sample meet in the same cycle. It then adds the overlapping stage codes into a single 14-bit word.

The stages overlap by one bit, and each three-level stage code spans two weights. Because of this, a stage comparator that fires early or late is repaired by the stages that follow it. Comparator offsets of up to about a quarter of the reference leave the corrected word equal to the ideal conversion.

The stream has no back-pressure. `in_valid` marks each conversion clock that carries fresh comparator data. Only those cycles advance the skew lines and the output register, so a low `in_valid` freezes the whole pipeline. The converter cannot pause, so there is no ready input. The consumer must take every word while `out_valid` is high, because the next advancing cycle replaces it.

Top module: `adc_corr_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_code` is 0. `out_valid` stays low for the first twelve advancing cycles after reset.
- R2: A stage comparator pair {upper, lower} decodes as follows: 00 gives 0, 01 gives 1, 11 gives 2. The illegal pattern 10 gives 1.
- R3: The flash code is the number of its three comparator bits that are set, for any pattern, including non-thermometer patterns such as 101, which gives 2.
- R4: Skew alignment works as follows. On the advancing cycle with index t, the pair of stage k (k = 1..12) belongs to sample t-k+1, and the flash bits belong to sample t-12. The word for sample s is loaded by the advancing edge of cycle s+12.
- R5: The word is the sum of d_k·2^(13-k) over stages k = 1..12, plus the flash code.
- R6: The comparator thresholds may sit anywhere within ±0.2 of their nominal ±1/4 of the reference, and may differ from stage to stage. Under such offsets, the word equals the ideal code floor(2^13·(v+1)) for an input v in [-1, 1).
- R7: All-zero comparators give 0 and all-set comparators give 16383. The sum saturates at 2^14-1 and never wraps.
- R8: A cycle with `in_valid` low is ignored. The next cycle has `out_valid` low and `out_code` unchanged, whatever is on the comparator inputs.
- R9: Once the pipeline is full, every advancing cycle raises `out_valid` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Current comparator inputs are a fresh conversion step |
| stage_cmp | input | 24 | Comparator pairs; stage k at bits [2k-1:2k-2], the upper comparator in the higher bit |
| flash_cmp | input | 3 | Final flash comparator outputs |
| out_valid | output | 1 | `out_code` was loaded on the previous edge |
| out_code | output | 14 | Corrected conversion word |

## Verification
Four behaviours are checked by assertions on every cycle: the fill rule, which keeps `out_valid` low until thirteen advances have occurred; that `out_valid` comes only one cycle after an advance; that every advance after fill yields a word; and that an idle cycle freezes the output. Three things depend on the bench's scenarios: the arithmetic of the overlap sum, the decoding of illegal comparator patterns, and whether the skew lines place each stage in the right sample. The bench runs a near-exhaustive sweep of every input code through a behavioural model of the stages, with random comparator offsets and random idle cycles. It also runs directed patterns that single out each stage weight and each illegal comparator pattern.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  typedef logic [1:0] stage_code_t;

  // Comparator pair {upper, lower} to a three-level stage decision.
  // The non-thermometer pattern 10 lies between 00 and 11, so it is
  // mapped onto the middle decision.
  function automatic stage_code_t decode_pair(input logic [1:0] cmp);
    stage_code_t d;
    unique case (cmp)
      2'b00:   d = 2'd0;
      2'b01:   d = 2'd1;
      2'b11:   d = 2'd2;
      default: d = 2'd1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/adc_stage_decode.sv
module adc_stage_decode #(
  parameter int NSTG = 12
) (
  input  logic [2*NSTG-1:0] raw_cmp,
  output logic [2*NSTG-1:0] codes
);
  import adc_corr_pkg::*;

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    assign codes[2*i +: 2] = decode_pair(raw_cmp[2*i +: 2]);
  end

endmodule

// File: rtl/adc_flash_decode.sv
module adc_flash_decode #(
  parameter int FLASH_CMP = 3,
  parameter int FLASH_W   = 2
) (
  input  logic [FLASH_CMP-1:0] raw_cmp,
  output logic [FLASH_W-1:0]   code
);
  // Population count: any bubble in the thermometer still lands on a
  // level that is adjacent to the true one.
  always_comb begin
    code = '0;
    for (int j = 0; j < FLASH_CMP; j++) begin
      code = code + FLASH_W'(raw_cmp[j]);
    end
  end

endmodule

// File: rtl/adc_skew_delay.sv
module adc_skew_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) sr[j] <= '0;
    end else if (en) begin
      sr[0] <= din;
      for (int j = 1; j < DEPTH; j++) sr[j] <= sr[j-1];
    end
  end

  assign dout = sr[DEPTH-1];

endmodule

// File: rtl/adc_code_combine.sv
module adc_code_combine #(
  parameter int NSTG    = 12,
  parameter int FLASH_W = 2,
  parameter int OUT_W   = NSTG + FLASH_W
) (
  input  logic [2*NSTG-1:0] aligned,
  input  logic [FLASH_W-1:0] flash,
  output logic [OUT_W-1:0]  code
);
  localparam int SUM_W = OUT_W + 1;

  logic [SUM_W-1:0] acc;

  // Stage k (index i = k-1) carries weight 2^(NSTG-i); adjacent stages
  // overlap by one bit, and the flash supplies the two lowest weights.
  always_comb begin
    acc = SUM_W'(flash);
    for (int i = 0; i < NSTG; i++) begin
      acc = acc + (SUM_W'(aligned[2*i +: 2]) << (NSTG - i));
    end
    code = acc[OUT_W] ? {OUT_W{1'b1}} : acc[OUT_W-1:0];
  end

endmodule

// File: rtl/adc_fill_tracker.sv
module adc_fill_tracker #(
  parameter int NSTG = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic full
);
  localparam int CNT_W = $clog2(NSTG + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (advance && cnt != CNT_W'(NSTG)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(NSTG));

endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top #(
  parameter int NSTG      = 12,
  parameter int FLASH_CMP = 3,
  parameter int FLASH_W   = 2,
  parameter int OUT_W     = NSTG + FLASH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2*NSTG-1:0] stage_cmp,
  input  logic [FLASH_CMP-1:0] flash_cmp,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_code
);
  logic [2*NSTG-1:0] codes;
  logic [2*NSTG-1:0] aligned;
  logic [FLASH_W-1:0] flash_code;
  logic [OUT_W-1:0]  sum_code;
  logic              full;

  adc_stage_decode #(.NSTG(NSTG)) u_sdec (
    .raw_cmp (stage_cmp),
    .codes   (codes)
  );

  adc_flash_decode #(.FLASH_CMP(FLASH_CMP), .FLASH_W(FLASH_W)) u_fdec (
    .raw_cmp (flash_cmp),
    .code    (flash_code)
  );

  // Stage k waits 13-k advances; the flash arrives last and needs none.
  for (genvar i = 0; i < NSTG; i++) begin : g_skew
    adc_skew_delay #(.W(2), .DEPTH(NSTG - i)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .din   (codes[2*i +: 2]),
      .dout  (aligned[2*i +: 2])
    );
  end

  adc_code_combine #(.NSTG(NSTG), .FLASH_W(FLASH_W), .OUT_W(OUT_W)) u_comb (
    .aligned (aligned),
    .flash   (flash_code),
    .code    (sum_code)
  );

  adc_fill_tracker #(.NSTG(NSTG)) u_fill (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (in_valid),
    .full    (full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid && full;
      if (in_valid) out_code <= sum_code;
    end
  end

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
  parameter int NSTG  = 12,
  parameter int OUT_W = NSTG + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_code
);
  localparam int CNT_W = $clog2(NSTG + 2) + 1;

  logic [CNT_W-1:0] adv_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) adv_cnt <= '0;
    else if (in_valid && adv_cnt != CNT_W'(NSTG + 1)) adv_cnt <= adv_cnt + 1'b1;
  end

  // R1: no word before thirteen advances since reset
  a_r1_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (adv_cnt == CNT_W'(NSTG + 1)));

  // R8: idle cycle leaves the output untouched
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_code) && !out_valid));

  // R9: a word appears after each advance once full
  a_r9_emit_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && adv_cnt >= CNT_W'(NSTG)) |=> out_valid);

  // R9: a word appears only after an advance
  a_r9_only_after_advance: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

endmodule

bind adc_corr_top adc_corr_chk #(.NSTG(NSTG), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_code  (out_code)
);

// File: tb/tb_adc_corr_top.sv
module tb_adc_corr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG = 12;
  localparam int SW   = 2 * NSTG;
  localparam int OUT_W = NSTG + 2;
  localparam int RING = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [SW-1:0] stage_cmp;
  logic [2:0] flash_cmp;
  logic out_valid;
  logic [OUT_W-1:0] out_code;

  int total = 0;
  int bad = 0;
  int t = 0;
  bit finished = 0;

  logic [SW-1:0] ring_s [RING];
  logic [2:0]    ring_f [RING];
  int            ring_e [RING];
  string         ring_r [RING];
  real offh [NSTG];
  real offl [NSTG];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_corr_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .stage_cmp(stage_cmp), .flash_cmp(flash_cmp),
    .out_valid(out_valid), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dec_pair(input logic [1:0] p);
    if (p == 2'b11) return 2;
    if (p == 2'b00) return 0;
    return 1;
  endfunction

  function automatic int expect_of(input logic [SW-1:0] sb, input logic [2:0] fb);
    int e = int'(fb[0]) + int'(fb[1]) + int'(fb[2]);
    for (int i = 0; i < NSTG; i++) e += dec_pair(sb[2*i +: 2]) << (NSTG - i);
    if (e > 16383) e = 16383;
    return e;
  endfunction

  // Behavioural stage chain with per-comparator offsets.
  task automatic convert(input int code, output logic [SW-1:0] sb, output logic [2:0] fb);
    real r;
    int d;
    bit hi, lo;
    r = (real'(code) + 0.5) / 8192.0 - 1.0;
    for (int i = 0; i < NSTG; i++) begin
      hi = (r > 0.25 + offh[i]);
      lo = (r > -0.25 + offl[i]);
      d = hi ? 2 : (lo ? 1 : 0);
      sb[2*i+1] = hi;
      sb[2*i]   = lo;
      r = 2.0 * r - real'(d - 1);
    end
    fb = {r >= 0.5, r >= 0.0, r >= -0.5};
  endtask

  task automatic draw_offsets();
    for (int i = 0; i < NSTG; i++) begin
      offh[i] = (real'($urandom_range(800)) - 400.0) / 2000.0;
      offl[i] = (real'($urandom_range(800)) - 400.0) / 2000.0;
    end
  endtask

  task automatic advance(input logic [SW-1:0] sb, input logic [2:0] fb,
                         input int e, input string req, input bit gap);
    logic [OUT_W-1:0] prev;
    if (gap) begin
      in_valid = 1'b0;
      stage_cmp = SW'({$urandom, $urandom});
      flash_cmp = 3'($urandom);
      prev = out_code;
      @(posedge clk); @(negedge clk);
      chk(!out_valid && out_code == prev, "R8", int'(out_code), int'(prev));
    end
    ring_s[t % RING] = sb;
    ring_f[t % RING] = fb;
    ring_e[t % RING] = e;
    ring_r[t % RING] = req;
    for (int i = 0; i < NSTG; i++)
      stage_cmp[2*i +: 2] = (t - i >= 0) ? ring_s[(t - i) % RING][2*i +: 2] : 2'b00;
    flash_cmp = (t >= NSTG) ? ring_f[(t - NSTG) % RING] : 3'b000;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    if (t >= NSTG) begin
      chk(out_valid, "R9", int'(out_valid), 1);
      chk(out_code == OUT_W'(ring_e[(t - NSTG) % RING]), ring_r[(t - NSTG) % RING],
          int'(out_code), ring_e[(t - NSTG) % RING]);
    end else begin
      chk(!out_valid, "R1", int'(out_valid), 0);
    end
    t++;
  endtask

  task automatic push(input logic [SW-1:0] sb, input logic [2:0] fb, input string req);
    advance(sb, fb, expect_of(sb, fb), req, 1'b0);
  endtask

  initial begin
    logic [SW-1:0] sb;
    logic [2:0] fb;
    rst_n = 1'b0; in_valid = 1'b0; stage_cmp = '0; flash_cmp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(!out_valid && out_code == '0, "R1", int'(out_code), 0);

    // R7 extremes
    push('0, 3'b000, "R7");
    push({SW{1'b1}}, 3'b111, "R7");
    // R5 all middle decisions: 8190
    sb = '0;
    for (int i = 0; i < NSTG; i++) sb[2*i +: 2] = 2'b01;
    push(sb, 3'b000, "R5");
    // R2 illegal pair in stage 5 decodes as middle: 256
    sb = '0; sb[2*4 +: 2] = 2'b10;
    push(sb, 3'b000, "R2");
    sb = '0; sb[0 +: 2] = 2'b10; sb[2*11 +: 2] = 2'b11;
    push(sb, 3'b000, "R2");
    // R3 flash non-thermometer patterns
    push('0, 3'b101, "R3");
    push('0, 3'b010, "R3");
    push('0, 3'b110, "R3");
    // R4 walking stage weights, one stage per sample
    for (int k = 0; k < NSTG; k++) begin
      sb = '0; sb[2*k +: 2] = 2'b11;
      push(sb, 3'b000, "R4");
    end
    sb = '0; sb[2*11 +: 2] = 2'b01;
    push(sb, 3'b011, "R5");
    // R8 an idle cycle with garbage inputs mid-stream
    advance('0, 3'b001, 1, "R8", 1'b1);

    // R6 full code sweep with comparator offsets and random idle cycles
    draw_offsets();
    for (int c = 0; c < 16384; c++) begin
      convert(c, sb, fb);
      advance(sb, fb, c, "R6", ($urandom_range(7) == 0));
    end
    draw_offsets();
    for (int n = 0; n < 2048; n++) begin
      int c = int'($urandom_range(16383));
      convert(c, sb, fb);
      advance(sb, fb, c, "R6", ($urandom_range(5) == 0));
    end
    // flush the skew lines
    for (int n = 0; n < NSTG; n++) push('0, 3'b000, "R7");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", t, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule